// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a serial memory slave on a two-wire clock and data bus. It samples the clock line and the data line with the system clock and removes short spikes from both. From the cleaned lines it recognises start and stop conditions and frames bytes. It answers its own device address and collects a word address. It then passes each written byte, or requests each byte to be read, over a plain strobe interface to the memory and write engine behind it.

The data pad is open drain. The block only decides when to pull the line low (`sda_oe`) and reads the line back on `sda_in`. Three strap inputs choose which of eight bus addresses the slave answers. While the write engine reports a programming cycle through `wr_busy`, the slave acknowledges nothing. Every change of `sda_oe` is held back by a fixed number of clocks after the clock line falls. This margin keeps a master from seeing a false start or stop.

Top module: `eeprom_serial_front`

## Requirements
- R1: After reset, `sda_oe` is 0 and `addr_valid`, `wr_valid`, `rd_req` and `stop_evt` are all 0.
- R2: A falling data line while the clock line is high is a start condition and opens the device address phase. A second start with no stop in between (a repeated start) also returns the slave to the device address phase.
- R3: A rising data line while the clock line is high is a stop condition. It ends any transfer and releases the data line. `stop_evt` pulses for one clock when the slave was selected at any point since the previous stop.
- R4: The device byte is sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `strap_sel[2:0]` (bit 3 against `strap_sel[2]`), and bit 0 is the direction (1 = read). On a match the slave holds the data line low through the high phase of the ninth clock pulse. On a mismatch it does not acknowledge and ignores the bus until the next start or stop.
- R5: After a write-direction device byte, the slave acknowledges two word address bytes. It then pulses `addr_valid` for one clock with `word_addr` = {low 4 bits of the first byte, second byte}. The upper 4 bits of the first byte are ignored.
- R6: Every further byte of a write is acknowledged and reported by a one-clock `wr_valid` pulse with the byte on `wr_data`. Any number of bytes may follow. At most one of `addr_valid`, `wr_valid`, `rd_req` and `stop_evt` is high in any clock.
- R7: In a read, `rd_req` pulses once per byte. `rd_data` is sampled on the clock edge at which `rd_req` rises, after which the supplier moves to its next byte. The byte is driven MSB first, one bit per clock pulse.
- R8: A master acknowledge (data line low in the ninth pulse) makes the slave send the next byte. A master non-acknowledge leaves the data line released, and no further `rd_req` is issued until a new start.
- R9: If `wr_busy` is high when any received byte completes, including the device byte, the slave does not acknowledge, issues no strobe for that byte, and ignores the bus until the next start or stop.
- R10: A pulse shorter than `FILT_CYC` clocks on either bus line has no effect on the transfer.
- R11: `sda_oe` changes only while the clock line is low, and never sooner than `HOLD_CYC` clocks after the clock line fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_sel | input | 3 | Device select straps compared with device byte bits 3..1 |
| wr_busy | input | 1 | Write engine is programming; no acknowledge while high |
| addr_valid | output | 1 | One-clock strobe: `word_addr` holds a new word address |
| word_addr | output | ADDR_W | Word address collected from the two address bytes |
| wr_valid | output | 1 | One-clock strobe: `wr_data` holds a received data byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-clock strobe: `rd_data` was taken for transmission |
| rd_data | input | 8 | Next byte to transmit |
| stop_evt | output | 1 | One-clock strobe on a stop that ends a selected transfer |

## Verification
The hardest case to reach is a short spike in the middle of a live write. A spike on the data line during a clock-high bit would be a false start. A spike on the clock line during a low phase would add a phantom bit. Either must leave the received byte intact. The stimulus places a 5-clock low pulse on the data line in the high phase of a 1 bit, and a 5-clock high pulse on the clock line in a later low phase, within one data byte. It then checks the acknowledge and the reported byte. Busy arriving after the word address is reached the same way: `wr_busy` is raised right after the second address byte is acknowledged, then a data byte is sent.

// File: rtl/eeprom_front_pkg.sv
`timescale 1ns/1ps
package eeprom_front_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        BK_DEV,
        BK_WHI,
        BK_WLO,
        BK_DATA
    } kind_e;

    localparam logic [3:0] CTRL_CODE = 4'b1010;

endpackage

// File: rtl/line_deglitch.sv
`timescale 1ns/1ps
module line_deglitch #(
    parameter int   FILT_CYC = 10,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          clean;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], raw};
        if (q.sync[1] == q.clean) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYC - 1)) begin
            d.clean = q.sync[1];
            d.cnt   = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= {2{IDLE_VAL}};
            q.cnt   <= '0;
            q.clean <= IDLE_VAL;
        end else begin
            q <= d;
        end
    end

    assign clean = q.clean;
endmodule

// File: rtl/bus_cond_det.sv
`timescale 1ns/1ps
module bus_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl_p = scl_c;
        d.sda_p = sda_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_rise   = !q.scl_p && scl_c;
    assign scl_fall   = q.scl_p && !scl_c;
    assign start_seen = q.scl_p && scl_c && q.sda_p && !sda_c;
    assign stop_seen  = q.scl_p && scl_c && !q.sda_p && sda_c;
endmodule

// File: rtl/sda_hold_gate.sv
`timescale 1ns/1ps
module sda_hold_gate #(
    parameter int HOLD_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_low,
    output logic sda_oe
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          oe;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (want_low == q.oe) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(HOLD_CYC - 1)) begin
            d.oe  = want_low;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/eeprom_serial_front.sv
`timescale 1ns/1ps
module eeprom_serial_front
    import eeprom_front_pkg::*;
#(
    parameter int FILT_CYC = 10,
    parameter int HOLD_CYC = 60,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        strap_sel,
    input  logic              wr_busy,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] word_addr,
    output logic              wr_valid,
    output logic [7:0]        wr_data,
    output logic              rd_req,
    input  logic [7:0]        rd_data,
    output logic              stop_evt
);
    localparam int HI_W   = ADDR_W - 8;
    localparam int LINE_N = 2;

    // Line cleaning: index 1 = clock line, index 0 = data line
    logic [LINE_N-1:0] raw_lines;
    logic [LINE_N-1:0] clean_lines;
    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < LINE_N; g++) begin : g_flt
        line_deglitch #(
            .FILT_CYC(FILT_CYC),
            .IDLE_VAL(1'b1)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    logic scl_c, sda_c;
    assign scl_c = clean_lines[1];
    assign sda_c = clean_lines[0];

    logic scl_rise, scl_fall, start_seen, stop_seen;

    bus_cond_det u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_c     (scl_c),
        .sda_c     (sda_c),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_seen(start_seen),
        .stop_seen (stop_seen)
    );

    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic [3:0]        bitcnt;
        logic [7:0]        shreg;
        logic              rw;
        logic [7:0]        hi_byte;
        logic              selected;
        logic              mack_ok;
        logic              drive_low;
        logic              addr_valid;
        logic [ADDR_W-1:0] word_addr;
        logic              wr_valid;
        logic [7:0]        wr_data;
        logic              rd_req;
        logic              stop_evt;
    } st_t;

    st_t q, d;

    function automatic kind_e next_kind(input kind_e k);
        case (k)
            BK_DEV:  return BK_WHI;
            BK_WHI:  return BK_WLO;
            default: return BK_DATA;
        endcase
    endfunction

    logic dev_hit;
    assign dev_hit = (q.shreg[7:4] == CTRL_CODE) && (q.shreg[3:1] == strap_sel);

    always_comb begin
        d            = q;
        d.addr_valid = 1'b0;
        d.wr_valid   = 1'b0;
        d.rd_req     = 1'b0;
        d.stop_evt   = 1'b0;

        if (stop_seen) begin
            d.phase     = PH_IDLE;
            d.drive_low = 1'b0;
            d.stop_evt  = q.selected;
            d.selected  = 1'b0;
        end else if (start_seen) begin
            d.phase     = PH_RX;
            d.kind      = BK_DEV;
            d.bitcnt    = 4'd0;
            d.drive_low = 1'b0;
        end else begin
            case (q.phase)
                PH_RX: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_c};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.bitcnt = 4'd0;
                        if (q.kind == BK_DEV) begin
                            if (dev_hit && !wr_busy) begin
                                d.rw        = q.shreg[0];
                                d.selected  = 1'b1;
                                d.drive_low = 1'b1;
                                d.phase     = PH_ACK;
                            end else begin
                                d.phase = PH_SKIP;
                            end
                        end else if (wr_busy) begin
                            d.phase = PH_SKIP;
                        end else begin
                            d.drive_low = 1'b1;
                            d.phase     = PH_ACK;
                            case (q.kind)
                                BK_WHI: d.hi_byte = q.shreg;
                                BK_WLO: begin
                                    d.addr_valid = 1'b1;
                                    d.word_addr  = {q.hi_byte[HI_W-1:0], q.shreg};
                                end
                                default: begin
                                    d.wr_valid = 1'b1;
                                    d.wr_data  = q.shreg;
                                end
                            endcase
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.drive_low = 1'b0;
                        d.bitcnt    = 4'd0;
                        if (q.kind == BK_DEV && q.rw) begin
                            d.rd_req    = 1'b1;
                            d.shreg     = rd_data;
                            d.drive_low = !rd_data[7];
                            d.phase     = PH_TX;
                        end else begin
                            d.phase = PH_RX;
                            d.kind  = next_kind(q.kind);
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.drive_low = 1'b0;
                            d.bitcnt    = 4'd0;
                            d.mack_ok   = 1'b0;
                            d.phase     = PH_MACK;
                        end else begin
                            d.shreg     = {q.shreg[6:0], 1'b0};
                            d.drive_low = !q.shreg[6];
                            d.bitcnt    = q.bitcnt + 4'd1;
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        d.mack_ok = !sda_c;
                    end else if (scl_fall) begin
                        if (q.mack_ok) begin
                            d.rd_req    = 1'b1;
                            d.shreg     = rd_data;
                            d.drive_low = !rd_data[7];
                            d.bitcnt    = 4'd0;
                            d.phase     = PH_TX;
                        end else begin
                            d.phase = PH_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    sda_hold_gate #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_low(q.drive_low),
        .sda_oe  (sda_oe)
    );

    assign addr_valid = q.addr_valid;
    assign word_addr  = q.word_addr;
    assign wr_valid   = q.wr_valid;
    assign wr_data    = q.wr_data;
    assign rd_req     = q.rd_req;
    assign stop_evt   = q.stop_evt;
endmodule

// File: rtl/eeprom_serial_front_chk.sv
`timescale 1ns/1ps
module eeprom_serial_front_chk #(
    parameter int HOLD_CYC = 60
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_oe,
    input logic addr_valid,
    input logic wr_valid,
    input logic rd_req,
    input logic stop_evt
);
    localparam int CW = $clog2(HOLD_CYC + 1) + 1;

    logic          scl_p;
    logic [CW-1:0] since_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p      <= 1'b1;
            since_fall <= '0;
        end else begin
            scl_p <= scl_in;
            if (scl_p && !scl_in) begin
                since_fall <= '0;
            end else if (since_fall < CW'(HOLD_CYC)) begin
                since_fall <= since_fall + CW'(1);
            end
        end
    end

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);

    p_hold_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (since_fall >= CW'(HOLD_CYC)));

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, wr_valid, rd_req, stop_evt}));

    p_addr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);

    p_rdreq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_stop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);
endmodule

bind eeprom_serial_front eeprom_serial_front_chk #(
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .addr_valid(addr_valid),
    .wr_valid  (wr_valid),
    .rd_req    (rd_req),
    .stop_evt  (stop_evt)
);

// File: tb/tb_eeprom_serial_front.sv
`timescale 1ns/1ps
module tb_eeprom_serial_front;
    localparam int ADDR_W = 12;
    localparam int HOLD   = 60;
    localparam int LOWW   = 160;
    localparam int HIGHW  = 120;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic m_scl, m_sda;
    logic [2:0] strap;
    logic busy;
    logic sda_oe, addr_valid, wr_valid, rd_req, stop_evt;
    logic [ADDR_W-1:0] word_addr;
    logic [7:0] wr_data, rd_data;
    logic line;

    assign line = m_sda & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    int n_addr = 0, n_wr = 0, n_rd = 0, n_stop = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [7:0] got_wr [0:31];
    int since_fall = 100000, min_gap = 100000, n_oe_hi = 0;
    logic scl_p = 1'b1, oe_p = 1'b0;

    function automatic logic [7:0] rd_mem(input int i);
        return 8'(i * 29 + 7);
    endfunction

    assign rd_data = rd_mem(n_rd);

    eeprom_serial_front #(.FILT_CYC(10), .HOLD_CYC(HOLD), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(line), .sda_oe(sda_oe),
        .strap_sel(strap), .wr_busy(busy), .addr_valid(addr_valid), .word_addr(word_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .stop_evt(stop_evt)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (addr_valid) begin n_addr <= n_addr + 1; last_addr <= word_addr; end
            if (wr_valid) begin got_wr[n_wr % 32] <= wr_data; n_wr <= n_wr + 1; end
            if (rd_req) n_rd <= n_rd + 1;
            if (stop_evt) n_stop <= n_stop + 1;
        end
        scl_p <= m_scl;
        oe_p  <= sda_oe;
        if (scl_p && !m_scl) since_fall <= 0;
        else if (since_fall < 100000) since_fall <= since_fall + 1;
        if (sda_oe != oe_p) begin
            if (since_fall < min_gap) min_gap <= since_fall;
            if (m_scl) n_oe_hi <= n_oe_hi + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; wt(HIGHW);
        m_sda = 1'b0; wt(HIGHW);
        m_scl = 1'b0;
    endtask

    task automatic m_rstart();
        wt(100); m_sda = 1'b1; wt(60); m_scl = 1'b1; wt(60);
        m_sda = 1'b0; wt(60); m_scl = 1'b0;
    endtask

    task automatic m_stop();
        wt(100); m_sda = 1'b0; wt(60); m_scl = 1'b1; wt(60);
        m_sda = 1'b1; wt(100);
    endtask

    task automatic m_bit_g(input logic b, input logic gs, input logic gc);
        if (gc) begin wt(30); m_scl = 1'b1; wt(5); m_scl = 1'b0; wt(65); end
        else wt(100);
        m_sda = b; wt(LOWW - 100); m_scl = 1'b1;
        if (gs) begin wt(40); m_sda = 1'b0; wt(5); m_sda = b; wt(HIGHW - 45); end
        else wt(HIGHW);
        m_scl = 1'b0;
    endtask

    task automatic m_rbit(output logic b);
        wt(100); m_sda = 1'b1; wt(LOWW - 100); m_scl = 1'b1;
        wt(HIGHW / 2); b = line; wt(HIGHW / 2);
        m_scl = 1'b0;
    endtask

    task automatic send_byte_g(input logic [7:0] v, input bit glitch, output logic ack);
        logic b;
        for (int i = 0; i < 8; i++)
            m_bit_g(v[7-i], glitch && (i == 2), glitch && (i == 4));
        m_rbit(b);
        ack = !b;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_byte_g(v, 1'b0, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin m_rbit(b); v[7-i] = b; end
        m_bit_g(!mack, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int s_addr, s_wr, s_rd, s_stop;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 3'b101; busy = 1'b0;
        wt(10); rst_n = 1'b1; wt(20);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 strobes", {addr_valid, wr_valid, rd_req, stop_evt}, 0);

        // Write with upper address bits set (ignored) and three data bytes
        s_addr = n_addr; s_wr = n_wr; s_stop = n_stop;
        m_start();
        send_byte({4'hA, strap, 1'b0}, ack); chk("R4 dev ack", ack, 1);
        send_byte(8'hF3, ack); chk("R5 hi ack", ack, 1);
        send_byte(8'h5A, ack); chk("R5 lo ack", ack, 1);
        chk("R5 addr count", n_addr - s_addr, 1);
        chk("R5 addr value", last_addr, 12'h35A);
        send_byte(8'h11, ack); chk("R6 d0 ack", ack, 1);
        send_byte(8'hC4, ack); chk("R6 d1 ack", ack, 1);
        send_byte(8'h7E, ack); chk("R6 d2 ack", ack, 1);
        chk("R6 count", n_wr - s_wr, 3);
        chk("R6 d0", got_wr[s_wr % 32], 8'h11);
        chk("R6 d1", got_wr[(s_wr + 1) % 32], 8'hC4);
        chk("R6 d2", got_wr[(s_wr + 2) % 32], 8'h7E);
        m_stop(); wt(20);
        chk("R3 stop pulse", n_stop - s_stop, 1);
        chk("R3 released", sda_oe, 0);

        // Random address read through repeated start
        s_addr = n_addr; s_rd = n_rd; s_stop = n_stop;
        m_start();
        send_byte({4'hA, strap, 1'b0}, ack); chk("R4 dev ack", ack, 1);
        send_byte(8'h00, ack); send_byte(8'h80, ack);
        chk("R5 addr 080", last_addr, 12'h080);
        m_rstart();
        send_byte({4'hA, strap, 1'b1}, ack); chk("R2 repeated start ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, v);
            chk("R7 read byte", v, rd_mem(s_rd + k));
        end
        wt(120);
        chk("R8 nack releases", sda_oe, 0);
        chk("R8 rd_req count", n_rd - s_rd, 4);
        m_stop(); wt(20);
        chk("R3 stop after read", n_stop - s_stop, 1);

        // Strap mismatch: no ack, rest ignored, no stop pulse
        s_addr = n_addr; s_stop = n_stop;
        m_start();
        send_byte({4'hA, strap ^ 3'b010, 1'b0}, ack); chk("R4 strap mismatch nack", ack, 0);
        send_byte(8'h12, ack); chk("R4 ignored after mismatch", ack, 0);
        m_stop(); wt(20);
        chk("R4 no strobes", n_addr - s_addr, 0);
        chk("R3 no stop pulse unselected", n_stop - s_stop, 0);

        // Control code mismatch
        m_start();
        send_byte({4'hB, strap, 1'b0}, ack); chk("R4 code mismatch nack", ack, 0);
        m_stop();

        // Busy during device byte
        busy = 1'b1; s_stop = n_stop;
        m_start();
        send_byte({4'hA, strap, 1'b0}, ack); chk("R9 busy dev nack", ack, 0);
        m_stop(); wt(20);
        chk("R9 no stop pulse", n_stop - s_stop, 0);
        busy = 1'b0;

        // Busy raised after word address
        s_wr = n_wr; s_stop = n_stop;
        m_start();
        send_byte({4'hA, strap, 1'b0}, ack);
        send_byte(8'h02, ack); send_byte(8'h40, ack); chk("R5 lo ack before busy", ack, 1);
        busy = 1'b1;
        send_byte(8'h99, ack); chk("R9 busy data nack", ack, 0);
        busy = 1'b0;
        send_byte(8'h66, ack); chk("R9 ignored after busy", ack, 0);
        chk("R9 no wr strobe", n_wr - s_wr, 0);
        m_stop(); wt(20);
        chk("R3 stop after selected", n_stop - s_stop, 1);

        // Spikes on both lines inside a data byte
        s_wr = n_wr;
        m_start();
        send_byte({4'hA, strap, 1'b0}, ack);
        send_byte(8'h01, ack); send_byte(8'h23, ack);
        send_byte_g(8'hB5, 1'b1, ack); chk("R10 glitch ack", ack, 1);
        chk("R10 glitch count", n_wr - s_wr, 1);
        chk("R10 glitch data", got_wr[s_wr % 32], 8'hB5);
        m_stop();

        // Random transactions
        for (int t = 0; t < 5; t++) begin
            logic hit, rw;
            logic [7:0] hi, lo, dv;
            int nb;
            strap = 3'($urandom);
            hit = ($urandom % 4) != 0;
            rw = 1'($urandom);
            nb = 1 + ($urandom % 3);
            s_addr = n_addr; s_wr = n_wr; s_rd = n_rd; s_stop = n_stop;
            m_start();
            send_byte({4'hA, hit ? strap : (strap ^ 3'(1 + $urandom % 7)), rw}, ack);
            chk("R4 random dev", ack, hit);
            if (hit && !rw) begin
                hi = 8'($urandom); lo = 8'($urandom);
                send_byte(hi, ack); send_byte(lo, ack);
                chk("R5 random addr", last_addr, {hi[3:0], lo});
                for (int k = 0; k < nb; k++) begin
                    dv = 8'($urandom);
                    send_byte(dv, ack);
                    chk("R6 random ack", ack, 1);
                    chk("R6 random data", got_wr[(s_wr + k) % 32], dv);
                end
            end else if (hit) begin
                for (int k = 0; k < nb; k++) begin
                    recv_byte(k != nb - 1, v);
                    chk("R7 random read", v, rd_mem(s_rd + k));
                end
                chk("R8 random rd count", n_rd - s_rd, nb);
            end
            m_stop(); wt(20);
            chk("R3 random stop", n_stop - s_stop, hit);
        end

        chk("R11 hold gap", (min_gap >= HOLD) ? 1 : 0, 1);
        chk("R11 no change with scl high", n_oe_hi, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule